// File: doc/BRIEF.md
# Store Vulnerability Window Load Filter

This block sits at the commit end of an out-of-order core. It decides, for each committing load, whether that load must be issued again to confirm the value it obtained speculatively. Stores carry sequence numbers that rise in program order. When a store writes the cache, its sequence number is recorded in a small table. The table is indexed by a slice of the store's word address.

Each committing load presents its address and a boundary. The boundary is the sequence number of the youngest store the load is known to follow. If the table shows a committed store to the load's slot that is younger than the boundary, the load is flagged for in-order re-execution. Otherwise it commits with no check. Because the table is indexed rather than tagged, two addresses can share one slot. Aliasing can therefore only add re-executions and never hides a conflict.

The sequence number is 16 bits wide. A store whose number is lower than the last committed one marks a wraparound. On a wraparound the table is emptied, and every load query is flagged for a short drain window.

Top module: `svw_load_filter`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rex_valid` and `rex_unsafe` are 0. After reset the table is empty, so a query to any address with boundary 0 returns `rex_unsafe`=0.
- R2: `rex_valid` is 1 in exactly the cycles that follow a cycle with `ld_valid`=1, and is 0 otherwise.
- R3: A query whose slot holds a committed store sequence number strictly greater than `ld_bound` returns `rex_unsafe`=1.
- R4: A query whose slot is empty, or holds a sequence number less than or equal to `ld_bound`, returns `rex_unsafe`=0. An equal value counts as safe.
- R5: The slot index is address bits [WORD_OFF+IDX_W-1:WORD_OFF], which are bits [5:2] by default. Addresses that differ only outside those bits share a slot and see the same recorded store.
- R6: A later store commit to a slot replaces the sequence number that slot held.
- R7: A store commit and a load query to the same slot in the same cycle: the query sees the new store's sequence number.
- R8: A store commit with a sequence number lower than the previous committed one is a wraparound. Every query in that cycle is flagged unsafe, and so is every query in the following WRAP_DRAIN-1 cycles (4 cycles in all by default).
- R9: After a wraparound, the table holds only stores committed from the wrapping store onward. Slots written before it read as empty.
- R10: `rex_unsafe` is never 1 while `rex_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | A store commits to the cache this cycle |
| st_addr | input | ADDR_W | Byte address of the committing store |
| st_seq | input | 16 | Sequence number of the committing store |
| ld_valid | input | 1 | A load asks for its verdict this cycle |
| ld_addr | input | ADDR_W | Byte address of the committing load |
| ld_bound | input | 16 | Sequence number of the youngest store the load follows |
| rex_valid | output | 1 | A verdict is presented this cycle |
| rex_unsafe | output | 1 | The load must be re-executed and its value compared |

## Verification
Each verdict is registered once. A query presented before a rising edge therefore shows on `rex_valid` and `rex_unsafe` just after that same edge, one cycle after the request. The store table is written on the same edge, with a bypass for a query in that cycle. The bench drives both ports on the falling edge and samples the verdict 1 ns after the rising edge. Consecutive stimulus tasks take consecutive cycles, so the four-cycle drain window after a wraparound can be counted exactly. The first query after the window is expected to come back safe.

// File: rtl/svw_pkg.sv
package svw_pkg;
  // Store sequence number width is fixed for the whole core.
  localparam int unsigned SEQ_W = 16;

  typedef logic [SEQ_W-1:0] seq_t;

  typedef struct packed {
    logic live;
    seq_t seq;
  } slot_t;

  // True when store number s falls inside the window of a load with boundary b.
  function automatic logic in_window(input seq_t s, input seq_t b);
    return s > b;
  endfunction

  // True when a new store number goes backwards, which marks a wraparound.
  function automatic logic seq_wrapped(input seq_t s_new, input seq_t s_last);
    return s_new < s_last;
  endfunction
endpackage

// File: rtl/svw_table.sv
module svw_table
  import svw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned WORD_OFF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  seq_t              wr_seq,
  input  logic              clr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_hit,
  output seq_t              rd_seq
);
  localparam int unsigned SLOTS = 1 << IDX_W;

  function automatic logic [IDX_W-1:0] slot_of(input logic [ADDR_W-1:0] a);
    return a[WORD_OFF +: IDX_W];
  endfunction

  slot_t             slots [SLOTS];
  logic [IDX_W-1:0]  wr_idx;
  logic [IDX_W-1:0]  rd_idx;
  logic              same_slot;

  assign wr_idx    = slot_of(wr_addr);
  assign rd_idx    = slot_of(rd_addr);
  assign same_slot = wr_en && (wr_idx == rd_idx);

  for (genvar e = 0; e < SLOTS; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slots[e] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(e))) begin
        slots[e].live <= 1'b1;
        slots[e].seq  <= wr_seq;
      end else if (clr) begin
        slots[e].live <= 1'b0;
      end
    end
  end

  // Same-cycle store to the queried slot is forwarded to the reader.
  always_comb begin
    if (same_slot) begin
      rd_hit = 1'b1;
      rd_seq = wr_seq;
    end else begin
      rd_hit = slots[rd_idx].live;
      rd_seq = slots[rd_idx].seq;
    end
  end
endmodule

// File: rtl/svw_wrap_ctrl.sv
module svw_wrap_ctrl
  import svw_pkg::*;
#(
  parameter int unsigned WRAP_DRAIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic st_valid,
  input  seq_t st_seq,
  output logic wrap_evt,
  output logic drain_active
);
  localparam int unsigned CNT_W = $clog2(WRAP_DRAIN + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(WRAP_DRAIN - 1);

  seq_t             last_seq;
  logic [CNT_W-1:0] drain_cnt;

  assign wrap_evt     = st_valid && seq_wrapped(st_seq, last_seq);
  assign drain_active = wrap_evt || (drain_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_seq  <= '0;
      drain_cnt <= '0;
    end else begin
      if (st_valid) last_seq <= st_seq;
      if (wrap_evt)             drain_cnt <= RELOAD;
      else if (drain_cnt != '0) drain_cnt <= drain_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/svw_load_filter.sv
module svw_load_filter
  import svw_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned IDX_W      = 4,
  parameter int unsigned WORD_OFF   = 2,
  parameter int unsigned WRAP_DRAIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [15:0]       st_seq,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [15:0]       ld_bound,
  output logic              rex_valid,
  output logic              rex_unsafe
);
  logic wrap_evt;
  logic drain_active;
  logic look_hit;
  seq_t look_seq;
  logic conflict;
  logic verdict;

  svw_wrap_ctrl #(.WRAP_DRAIN(WRAP_DRAIN)) u_wrap (
    .clk          (clk),
    .rst_n        (rst_n),
    .st_valid     (st_valid),
    .st_seq       (st_seq),
    .wrap_evt     (wrap_evt),
    .drain_active (drain_active)
  );

  svw_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WORD_OFF(WORD_OFF)) u_tab (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (st_valid),
    .wr_addr (st_addr),
    .wr_seq  (st_seq),
    .clr     (wrap_evt),
    .rd_addr (ld_addr),
    .rd_hit  (look_hit),
    .rd_seq  (look_seq)
  );

  assign conflict = look_hit && in_window(look_seq, ld_bound);
  assign verdict  = drain_active || conflict;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rex_valid  <= 1'b0;
      rex_unsafe <= 1'b0;
    end else begin
      rex_valid  <= ld_valid;
      rex_unsafe <= ld_valid && verdict;
    end
  end
endmodule

// File: rtl/svw_load_filter_chk.sv
module svw_load_filter_chk #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned WORD_OFF = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_valid,
  input logic [ADDR_W-1:0] st_addr,
  input logic [15:0]       st_seq,
  input logic              ld_valid,
  input logic [ADDR_W-1:0] ld_addr,
  input logic [15:0]       ld_bound,
  input logic              rex_valid,
  input logic              rex_unsafe,
  input logic              wrap_evt
);
  logic same_slot_young;
  assign same_slot_young = st_valid && ld_valid &&
                           (st_addr[WORD_OFF +: IDX_W] == ld_addr[WORD_OFF +: IDX_W]) &&
                           (st_seq > ld_bound);

  p_verdict_follows_query_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> rex_valid);

  p_no_verdict_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> !rex_valid);

  p_unsafe_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rex_valid |-> !rex_unsafe);

  p_bypass_seen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    same_slot_young |=> rex_unsafe);

  p_wrap_flags_query_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && ld_valid) |=> rex_unsafe);
endmodule

bind svw_load_filter svw_load_filter_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WORD_OFF(WORD_OFF)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .st_valid   (st_valid),
  .st_addr    (st_addr),
  .st_seq     (st_seq),
  .ld_valid   (ld_valid),
  .ld_addr    (ld_addr),
  .ld_bound   (ld_bound),
  .rex_valid  (rex_valid),
  .rex_unsafe (rex_unsafe),
  .wrap_evt   (wrap_evt)
);

// File: tb/tb_svw_load_filter.sv
`timescale 1ns/1ps
module tb_svw_load_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic [15:0] st_seq = '0;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_addr = '0;
  logic [15:0] ld_bound = '0;
  logic        rex_valid;
  logic        rex_unsafe;

  int n_checks = 0;
  int n_fail   = 0;
  logic got_v, got_u;

  always #2.5 clk = ~clk;

  svw_load_filter dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_seq(st_seq),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_bound(ld_bound),
    .rex_valid(rex_valid), .rex_unsafe(rex_unsafe)
  );

  // Bench's own view of the slot index: bits [5:2].
  localparam logic [31:0] A_SLOT0  = 32'h100;
  localparam logic [31:0] A_SLOT1  = 32'h104;
  localparam logic [31:0] A_SLOT2  = 32'h108;
  localparam logic [31:0] A_SLOT3  = 32'h10C;
  localparam logic [31:0] A_SLOT4  = 32'h110;
  localparam logic [31:0] A_ALIAS0 = 32'h140;
  localparam logic [31:0] A_BYTE0  = 32'h103;

  task automatic check(input string req, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic step(input logic sv, input logic [31:0] sa, input logic [15:0] ss,
                      input logic lv, input logic [31:0] la, input logic [15:0] lb);
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_seq = ss;
    ld_valid = lv; ld_addr = la; ld_bound = lb;
    @(posedge clk);
    #1;
    got_v = rex_valid;
    got_u = rex_unsafe;
    st_valid = 1'b0;
    ld_valid = 1'b0;
  endtask

  task automatic query(input string req, input logic [31:0] la, input logic [15:0] lb,
                       input logic exp_u);
    step(1'b0, '0, '0, 1'b1, la, lb);
    check({req, " valid"}, got_v, 1'b1);
    check(req, got_u, exp_u);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid in reset", rex_valid, 1'b0);
    check("R1 unsafe in reset", rex_unsafe, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 valid after reset", rex_valid, 1'b0);
    check("R1 unsafe after reset", rex_unsafe, 1'b0);
    query("R1 empty table", A_SLOT0, 16'd0, 1'b0);
  endtask

  task automatic t_basic();
    step(1'b1, A_SLOT0, 16'd10, 1'b0, '0, '0);
    check("R2 no query no verdict", got_v, 1'b0);
    check("R10 idle unsafe low", got_u, 1'b0);
    query("R3 younger store", A_SLOT0, 16'd5, 1'b1);
    query("R4 equal boundary", A_SLOT0, 16'd10, 1'b0);
    query("R4 older store", A_SLOT0, 16'd11, 1'b0);
    query("R4 empty slot", A_SLOT1, 16'd0, 1'b0);
  endtask

  task automatic t_alias();
    query("R5 alias upper bits", A_ALIAS0, 16'd5, 1'b1);
    query("R5 byte offset", A_BYTE0, 16'd5, 1'b1);
  endtask

  task automatic t_overwrite();
    step(1'b1, A_ALIAS0, 16'd20, 1'b0, '0, '0);
    query("R6 newer seq kept", A_SLOT0, 16'd15, 1'b1);
    query("R6 newer seq safe", A_SLOT0, 16'd20, 1'b0);
  endtask

  task automatic t_bypass();
    step(1'b1, A_SLOT1, 16'd30, 1'b1, A_SLOT1, 16'd25);
    check("R7 bypass valid", got_v, 1'b1);
    check("R7 same cycle store seen", got_u, 1'b1);
    step(1'b1, A_SLOT2, 16'd31, 1'b1, A_SLOT1, 16'd30);
    check("R7 other slot not forwarded", got_u, 1'b0);
  endtask

  task automatic t_wrap();
    step(1'b1, A_SLOT3, 16'd2, 1'b1, A_SLOT1, 16'd100);
    check("R8 wrap cycle unsafe", got_u, 1'b1);
    for (int k = 0; k < 3; k++) query("R8 drain window", A_SLOT4, 16'd1000, 1'b1);
    query("R9 window over", A_SLOT4, 16'd1000, 1'b0);
    query("R9 old entry cleared", A_SLOT0, 16'd0, 1'b0);
    query("R9 wrapping store kept", A_SLOT3, 16'd1, 1'b1);
    query("R9 wrapping store safe", A_SLOT3, 16'd2, 1'b0);
    step(1'b0, '0, '0, 1'b0, '0, '0);
    check("R2 verdict drops", got_v, 1'b0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_alias();
    t_overwrite();
    t_bypass();
    t_wrap();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #50000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule